// File: doc/BRIEF.md
# Flash Command Launch Controller

This block is the register front end that sits between a host bus and a flash memory engine. The host loads a divider setting, stages a command code and its operands in a small bank of parameter words, and launches the command by writing 1 to a completion flag in the status register. Before it hands the command to the engine, the block checks the preconditions. A command is refused with an access error if its code is not known, or if it is a program or erase and the divider has never been written. A program or erase whose target address lies in the protected region is refused with a protection error. A launch is also refused while either error flag is still set.

While a command runs, the completion flag reads 0, the parameter bank is frozen and further launches are ignored. When the engine finishes, the flag returns to 1 and one parameter word holds the result. The engine in this project is a stub. It takes a fixed number of cycles and returns a result computed from the operands, so the launch path can be checked end to end.

The host port is a plain register port. Writes are taken at the clock edge while `reg_we` is high, with no back-pressure, and reads are combinational from `reg_addr`. Inside the block the command travels to the engine on a valid/ready pair. The front end raises valid for one cycle and only when the engine is idle, so ready never stalls it. The engine answers with a one-cycle response-valid strobe.

Top module: `fcmd_launch_ctrl`

## Requirements
- R1: After reset, status (address 1) reads 0x0080, divider (address 0) reads 0x0000, index (address 2) reads 0x0000 and the parameter window (address 3) reads 0x0000.
- R2: A write to address 0 stores bits [6:0] as the divider and sets the loaded flag, which reads at bit 7 of address 0. The flag stays 1 after any later write and clears only on reset.
- R3: The index register (address 2, bits [2:0]) selects which parameter word address 3 reads and writes. Words 0 to 5 are read/write storage. Index 6 and 7 read as 0, and writes through them change no word.
- R4: Writing status with bit 7 = 1, while no error is pending and the checks pass, launches the command. Status bit 7 reads 0 after that edge and reads 1 again exactly LAT (default 8) clock edges after the launch edge. Word 5 then holds word0 + word1 + word2, modulo 2^16.
- R5: While status bit 7 is 0, writes to the parameter window are ignored and a further write of bit 7 = 1 has no effect.
- R6: The command code is the upper byte of word 0. The codes are 0x01 verify, 0x02 program and 0x03 erase. Any other code sets the access-error flag (status bit 5) and does not launch.
- R7: A program or erase launched while the divider-loaded flag is 0 sets status bit 5 and does not launch. A verify command does not depend on the divider.
- R8: A program or erase whose address operand (word 1) is 0xC000 or higher sets the protection-error flag (status bit 4) and does not launch. An address of 0xBFFF launches. A verify command is not subject to this check.
- R9: While status bit 5 or bit 4 is 1, writing bit 7 = 1 launches nothing, and the status value is unchanged by that write.
- R10: Status bits 5 and 4 clear when written with 1. Writing 0 to any status bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe, taken at the rising edge |
| reg_addr | input | 2 | Register select: 0 divider, 1 status, 2 index, 3 parameter window |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |

## Verification
Register writes show in the read data right after the edge that takes them. So the bench drives each write between falling edges and reads back half a cycle after the next falling edge. Refusals and error flags appear on that first readback: status reads 0x00A0 or 0x0090 with bit 7 still 1. For an accepted launch, bit 7 is checked low on the first readback. The bench counts rising edges from the launch edge and requires the flag to return at exactly edge LAT, and it reads the word-5 result only after that. The writes the bench makes while busy fall inside that window, and their absence of effect is read back after completion.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  typedef enum logic [1:0] {
    A_DIV  = 2'd0,
    A_STAT = 2'd1,
    A_IDX  = 2'd2,
    A_PAR  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    V_GO  = 2'd0,
    V_ACC = 2'd1,
    V_PV  = 2'd2
  } verdict_e;

  localparam logic [7:0] OP_VERIFY = 8'h01;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_ERASE  = 8'h03;

  localparam int ST_DONE = 7;
  localparam int ST_ACC  = 5;
  localparam int ST_PV   = 4;
  localparam int DIV_LD  = 7;
endpackage

// File: rtl/fcl_cmd_check.sv
module fcl_cmd_check
  import fcl_pkg::*;
#(
  parameter int DW = 16,
  parameter logic [DW-1:0] PROT_LIMIT = 16'hC000
) (
  input  logic [7:0]    op,
  input  logic [DW-1:0] target,
  input  logic          div_loaded,
  output verdict_e      verdict
);
  always_comb begin
    unique case (op)
      OP_VERIFY: verdict = V_GO;
      OP_PROG, OP_ERASE: begin
        if (!div_loaded)               verdict = V_ACC;
        else if (target >= PROT_LIMIT) verdict = V_PV;
        else                           verdict = V_GO;
      end
      default: verdict = V_ACC;
    endcase
  end
endmodule

// File: rtl/fcl_param_bank.sv
module fcl_param_bank #(
  parameter int DW      = 16,
  parameter int NW      = 6,
  parameter int IW      = 3,
  parameter int RES_IDX = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] host_wdata,
  input  logic          res_we,
  input  logic [DW-1:0] res_data,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] w0_o,
  output logic [DW-1:0] w1_o,
  output logic [DW-1:0] w2_o
);
  logic [DW-1:0] word_q [NW];

  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[i] <= '0;
      else if (res_we && (i == RES_IDX))
        word_q[i] <= res_data;
      else if (host_we && (idx == IW'(i)))
        word_q[i] <= host_wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NW; i++)
      if (idx == IW'(i)) rd_data = word_q[i];
  end

  assign w0_o = word_q[0];
  assign w1_o = word_q[1];
  assign w2_o = word_q[2];
endmodule

// File: rtl/fcl_stub_engine.sv
module fcl_stub_engine #(
  parameter int DW  = 16,
  parameter int LAT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] w0,
  input  logic [DW-1:0] w1,
  input  logic [DW-1:0] w2,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] res_q;

  assign req_ready = !busy_q;
  assign rsp_valid = busy_q && (cnt_q == '0);
  assign rsp_data  = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
    end else if (req_valid && req_ready) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(LAT - 1);
      res_q  <= w0 + w1 + w2;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fcmd_launch_ctrl.sv
module fcmd_launch_ctrl
  import fcl_pkg::*;
#(
  parameter int DW      = 16,
  parameter int NW      = 6,
  parameter int IW      = 3,
  parameter int DIVW    = 7,
  parameter int LAT     = 8,
  parameter int RES_IDX = 5,
  parameter logic [DW-1:0] PROT_LIMIT = 16'hC000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  localparam int OPW = 8;

  logic            wr_div, wr_stat, wr_idx, wr_par;
  logic [DIVW-1:0] div_q;
  logic            div_ld_q;
  logic [IW-1:0]   idx_q;
  logic            cc_q, acc_q, pv_q;
  logic            launch_try, req_valid, req_ready, rsp_valid;
  logic            acc_set, pv_set;
  logic [DW-1:0]   par_rd, rsp_data, w0, w1, w2;
  logic [OPW-1:0]  op_w;
  verdict_e        verdict;

  assign wr_div  = reg_we && (reg_addr == A_DIV);
  assign wr_stat = reg_we && (reg_addr == A_STAT);
  assign wr_idx  = reg_we && (reg_addr == A_IDX);
  assign wr_par  = reg_we && (reg_addr == A_PAR);
  assign op_w    = w0[DW-1 -: OPW];

  fcl_cmd_check #(.DW(DW), .PROT_LIMIT(PROT_LIMIT)) u_check (
    .op(op_w), .target(w1), .div_loaded(div_ld_q), .verdict(verdict)
  );

  assign launch_try = wr_stat && reg_wdata[ST_DONE] && cc_q && !acc_q && !pv_q;
  assign req_valid  = launch_try && (verdict == V_GO);
  assign acc_set    = launch_try && (verdict == V_ACC);
  assign pv_set     = launch_try && (verdict == V_PV);

  fcl_param_bank #(.DW(DW), .NW(NW), .IW(IW), .RES_IDX(RES_IDX)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .host_we(wr_par && cc_q), .idx(idx_q), .host_wdata(reg_wdata),
    .res_we(rsp_valid), .res_data(rsp_data),
    .rd_data(par_rd), .w0_o(w0), .w1_o(w1), .w2_o(w2)
  );

  fcl_stub_engine #(.DW(DW), .LAT(LAT)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .w0(w0), .w1(w1), .w2(w2),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      div_ld_q <= 1'b0;
      idx_q    <= '0;
      cc_q     <= 1'b1;
      acc_q    <= 1'b0;
      pv_q     <= 1'b0;
    end else begin
      if (wr_div) begin
        div_q    <= reg_wdata[DIVW-1:0];
        div_ld_q <= 1'b1;
      end
      if (wr_idx) idx_q <= reg_wdata[IW-1:0];
      if (rsp_valid)                   cc_q <= 1'b1;
      else if (req_valid && req_ready) cc_q <= 1'b0;
      acc_q <= (acc_q && !(wr_stat && reg_wdata[ST_ACC])) || acc_set;
      pv_q  <= (pv_q  && !(wr_stat && reg_wdata[ST_PV]))  || pv_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_DIV: begin
        reg_rdata[DIVW-1:0] = div_q;
        reg_rdata[DIV_LD]   = div_ld_q;
      end
      A_STAT: begin
        reg_rdata[ST_DONE] = cc_q;
        reg_rdata[ST_ACC]  = acc_q;
        reg_rdata[ST_PV]   = pv_q;
      end
      A_IDX:   reg_rdata[IW-1:0] = idx_q;
      default: reg_rdata = par_rd;
    endcase
  end
endmodule

// File: rtl/fcl_chk.sv
module fcl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cc,
  input logic          acc,
  input logic          pv,
  input logic          loaded,
  input logic          req_valid,
  input logic          rsp_valid,
  input logic [7:0]    op,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_wdata
);
  // R4
  launch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !cc);
  // R4
  finish_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> cc);
  // R5
  busy_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cc |-> !req_valid);
  // R9
  err_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc || pv) |-> !req_valid);
  // R7
  div_before_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (op == 8'h02 || op == 8'h03)) |-> loaded);
  // R6
  known_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (op == 8'h01 || op == 8'h02 || op == 8'h03));
  // R2
  loaded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);
  // R10
  acc_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && reg_we && reg_addr == 2'd1 && reg_wdata[5]) |=> !acc);
endmodule

bind fcmd_launch_ctrl fcl_chk #(.DW(DW)) u_fcl_chk (
  .clk(clk), .rst_n(rst_n), .cc(cc_q), .acc(acc_q), .pv(pv_q),
  .loaded(div_ld_q), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .op(op_w), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/test_fcmd_launch_ctrl.sv
module test_fcmd_launch_ctrl;
  localparam int LAT = 8;
  localparam logic [1:0] AD = 2'd0, AS = 2'd1, AI = 2'd2, AP = 2'd3;

  // {code[8], word1[16], word2[16], kind[2]}; kind 0 launch, 1 access error, 2 protection error
  localparam logic [41:0] VEC [8] = '{
    {8'h01, 16'h1234, 16'h1111, 2'd0},
    {8'h02, 16'h0100, 16'h0002, 2'd0},
    {8'h03, 16'hBFFF, 16'h0001, 2'd0},
    {8'h02, 16'hC000, 16'h0000, 2'd2},
    {8'h03, 16'hFFFF, 16'h0005, 2'd2},
    {8'h00, 16'h0000, 16'h0000, 2'd1},
    {8'h04, 16'h0001, 16'h0001, 2'd1},
    {8'h01, 16'hF000, 16'h1000, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  int          total = 0, bad = 0, cyc = 0;

  fcmd_launch_ctrl #(.LAT(LAT)) i_fcmd_launch_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdchk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic setp(input logic [15:0] i, input logic [15:0] d);
    wr(AI, i);
    wr(AP, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdchk(AS, 16'h0080, "R1 status");
    rdchk(AD, 16'h0000, "R1 divider");
    rdchk(AI, 16'h0000, "R1 index");
    rdchk(AP, 16'h0000, "R1 window");

    // R3 window storage and out-of-range index
    for (int i = 0; i < 6; i++) setp(16'(i), 16'h1000 + 16'(i));
    for (int i = 0; i < 6; i++) begin
      wr(AI, 16'(i));
      rdchk(AP, 16'h1000 + 16'(i), "R3 readback");
    end
    setp(16'd6, 16'hBEEF);
    rdchk(AP, 16'h0000, "R3 index 6 reads zero");
    wr(AI, 16'd7);
    rdchk(AP, 16'h0000, "R3 index 7 reads zero");
    for (int i = 0; i < 6; i++) begin
      wr(AI, 16'(i));
      rdchk(AP, 16'h1000 + 16'(i), "R3 untouched by index 6");
    end

    // R7 program refused before the divider is written
    setp(16'd0, 16'h0200);
    setp(16'd1, 16'h0010);
    wr(AS, 16'h0080);
    rdchk(AS, 16'h00A0, "R7 program without divider");

    // R9 launch of a valid verify refused while the error is pending
    setp(16'd0, 16'h0100);
    wr(AS, 16'h0080);
    rdchk(AS, 16'h00A0, "R9 refused while error set");
    // R10 zero write has no effect, one clears
    wr(AS, 16'h0000);
    rdchk(AS, 16'h00A0, "R10 zero write");
    wr(AS, 16'h0020);
    rdchk(AS, 16'h0080, "R10 one clears");

    // R2 divider and loaded flag
    rdchk(AD, 16'h0000, "R2 not loaded yet");
    wr(AD, 16'h0015);
    rdchk(AD, 16'h0095, "R2 loaded with value");
    wr(AD, 16'h0000);
    rdchk(AD, 16'h0080, "R2 flag sticky");

    // Vector table: R4 R6 R8
    for (int v = 0; v < 8; v++) begin
      logic [7:0]  code;
      logic [15:0] a, b, res;
      logic [1:0]  kind;
      code = VEC[v][41:34]; a = VEC[v][33:18]; b = VEC[v][17:2]; kind = VEC[v][1:0];
      res = {code, 8'h00} + a + b;
      setp(16'd0, {code, 8'h00});
      setp(16'd1, a);
      setp(16'd2, b);
      wr(AS, 16'h0080);
      if (kind == 2'd0) begin
        rdchk(AS, 16'h0000, "R4 busy after launch");
        repeat (LAT + 1) @(negedge clk);
        rdchk(AS, 16'h0080, "R4 complete");
        wr(AI, 16'd5);
        rdchk(AP, res, "R4 result word");
      end else if (kind == 2'd1) begin
        rdchk(AS, 16'h00A0, "R6 unknown code");
        wr(AS, 16'h0020);
        rdchk(AS, 16'h0080, "R10 clear access error");
      end else begin
        rdchk(AS, 16'h0090, "R8 protected address");
        wr(AS, 16'h0010);
        rdchk(AS, 16'h0080, "R10 clear protection error");
      end
    end

    // R4 exact latency, R5 writes ignored while busy
    setp(16'd0, 16'h0100);
    setp(16'd1, 16'h0005);
    setp(16'd2, 16'h0006);
    wr(AS, 16'h0080);
    t0 = cyc;
    rdchk(AS, 16'h0000, "R5 busy");
    setp(16'd1, 16'h7777);
    wr(AS, 16'h0080);
    for (int k = 0; k < 100; k++) begin
      reg_addr = AS;
      #1;
      d = reg_rdata;
      if (d[7]) break;
      @(negedge clk);
    end
    chk("R4 latency", 16'(cyc - t0), 16'(LAT));
    rdchk(AS, 16'h0080, "R5 second launch ignored");
    wr(AI, 16'd1);
    rdchk(AP, 16'h0005, "R5 busy write ignored");
    wr(AI, 16'd5);
    rdchk(AP, 16'h010B, "R4 result after wait");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule